// File: doc/BRIEF.md
# Vector Branch Condition Evaluator

This block reduces a predicated vector of condition bits to a single branch decision. A start pulse latches a vector length, the two BO control bits, the 5-bit BI selector, a 5-bit mode field, an Rc enable and a 64-bit predicate mask. The block then visits element indices in ascending order, one per clock. For each element it reads a 4-bit condition field through a combinational read port and picks one bit from it. It tests that bit against BO and folds the result into an accumulated condition, either as an AND over all elements or as an OR over any of them.

Evaluation stops early at the first element that settles the outcome. A masked element is either skipped or tested with a fixed inserted value. In vector-length-set modes the first failing element also truncates the vector length. When the block finishes it reports the taken decision, the optional new vector length and the number of predicated-in elements it tested, which is the amount to subtract from the loop counter. With Rc enabled it also copies each field it read into a per-element result field through a separate write port.

Top module: `vbranch_eval`

## Requirements
- R1: Field address: with `bi_vec`=1 element s reads field ({bi[4:2],4'b0000} + s) mod 128; with `bi_vec`=0 every element reads field bi[4:2]. The test bit is bit bi[1:0] of the 4-bit field read.
- R2: Element result ok = bo[0] | ~(testbit ^ bo[1]). bo[0]=1 forces a pass; bo[1] selects whether a 1 (bo[1]=1) or a 0 (bo[1]=0) passes.
- R3: Mode field layout: mode[4:3] selects 00 normal, 01 length-set, 10 step, 11 step plus length-set; step variants evaluate like their non-step counterparts. mode[1] is ALL and mode[0] is sz. mode[2] is the inserted value in selects 00/10 and the inclusive flag in selects 01/11, where the inserted value is 0. With ALL the accumulated condition starts at 1 and is ANDed with each result; otherwise it starts at 0 and is ORed. `taken` is the final accumulated value.
- R4: An element with pred[s]=0 is skipped when sz=0. When sz=1 it is tested with the inserted value in place of the field bit, and no field is read for it.
- R5: Elements are evaluated in ascending order, one per clock, while `busy` is high. With ALL the run stops after the first failing tested element; otherwise it stops after the first passing one. `busy` is high for exactly (stop index + 1) cycles, or VL cycles when no stop occurs.
- R6: In the length-set modes the first failing tested element ends the run with `vl_update_valid`=1 and `new_vl` = s+1 if the inclusive flag is set, s otherwise. Otherwise `vl_update_valid`=0.
- R7: With `rc_en`=1 each predicated-in element s that is evaluated writes the 4-bit field it read to field s. Nothing is written for skipped, masked or unreached elements, or when `rc_en`=0.
- R8: `ctr_dec_count` equals the number of evaluated elements with pred[s]=1.
- R9: A start with VL=0 produces `done` on the next cycle with `taken` = ALL, `vl_update_valid`=0 and `ctr_dec_count`=0, and writes no field.
- R10: After reset `busy` and `done` are 0. `done` is a one-cycle pulse in the cycle after the last evaluated element, and the results hold until the next start. A `start` pulse while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Latch the operands and begin evaluation |
| vl | input | 7 | Vector length, 0 to 64 |
| bo | input | 2 | bo[0] forces pass, bo[1] selects the passing bit value |
| bi | input | 5 | Field selector (upper 3 bits) and bit selector (lower 2 bits) |
| bi_vec | input | 1 | 1 when the field index advances with the element |
| mode | input | 5 | Mode select, inserted value or inclusive flag, ALL, sz |
| rc_en | input | 1 | Copy each field read to field s |
| pred | input | 64 | Predicate mask, bit s for element s |
| cf_rd_addr | output | 7 | Condition-field read address |
| cf_rd_data | input | 4 | Condition-field read data, combinational |
| cf_wr_en | output | 1 | Result-field write enable |
| cf_wr_addr | output | 7 | Result-field write address |
| cf_wr_data | output | 4 | Result-field write data |
| busy | output | 1 | Evaluating elements |
| done | output | 1 | One-cycle completion pulse |
| taken | output | 1 | Branch decision |
| vl_update_valid | output | 1 | New vector length is valid |
| new_vl | output | 7 | Truncated vector length |
| ctr_dec_count | output | 7 | Counter decrement amount |

## Verification
The assertions check on every cycle the handshake shape: `done` lasts one cycle and never overlaps `busy`, and writes happen only while busy and to a field below 64. They also check the limits on the decrement count and the new length, and that a truncation never coexists with a taken branch. The decision value, the stopping point, the exact truncated length and the contents of the result fields depend on the data. Only the bench's sweep can show them, because it compares every run against an arithmetic model of the ordered, early-exiting fold.

// File: rtl/vbe_pkg.sv
package vbe_pkg;
    localparam int VL_MAX   = 64;
    localparam int CF_COUNT = 128;
    localparam int CF_W     = 4;
    localparam int IDX_W    = $clog2(VL_MAX + 1);
    localparam int CF_AW    = $clog2(CF_COUNT);

    typedef enum logic [1:0] {PH_IDLE, PH_RUN, PH_FIN} phase_t;

    typedef struct packed {
        logic [1:0]        bo;
        logic [4:0]        bi;
        logic              bi_vec;
        logic [4:0]        mode;
        logic              rc_en;
        logic [VL_MAX-1:0] pred;
        logic [IDX_W-1:0]  vl;
    } cfg_t;

    typedef struct packed {
        phase_t           phase;
        cfg_t             cfg;
        logic [IDX_W-1:0] idx;
        logic             cond;
        logic [IDX_W-1:0] cnt;
        logic             vlu;
        logic [IDX_W-1:0] nvl;
    } state_t;
endpackage

// File: rtl/vbe_addr_gen.sv
module vbe_addr_gen #(
    parameter int IDX_W = 7,
    parameter int CF_AW = 7
) (
    input  logic [2:0]       bi_hi,
    input  logic             bi_vec,
    input  logic [IDX_W-1:0] idx,
    output logic [CF_AW-1:0] addr
);
    localparam int SHIFT = CF_AW - 3;
    logic [CF_AW-1:0] base_v;
    logic [CF_AW-1:0] idx_x;

    always_comb begin
        base_v = {bi_hi, {SHIFT{1'b0}}};
        idx_x  = CF_AW'(idx);
        addr   = bi_vec ? (base_v + idx_x) : CF_AW'(bi_hi);
    end
endmodule

// File: rtl/vbe_elem_test.sv
module vbe_elem_test #(
    parameter int CF_W = 4
) (
    input  logic [CF_W-1:0] field,
    input  logic [1:0]      bit_sel,
    input  logic            pred_bit,
    input  logic            sz,
    input  logic            ins_val,
    input  logic [1:0]      bo,
    output logic            evaluate,
    output logic            el_ok
);
    logic test_bit;

    always_comb begin
        evaluate = pred_bit | sz;
        test_bit = pred_bit ? field[bit_sel] : ins_val;
        el_ok    = bo[0] | ~(test_bit ^ bo[1]);
    end
endmodule

// File: rtl/vbranch_eval.sv
module vbranch_eval
    import vbe_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [IDX_W-1:0]  vl,
    input  logic [1:0]        bo,
    input  logic [4:0]        bi,
    input  logic              bi_vec,
    input  logic [4:0]        mode,
    input  logic              rc_en,
    input  logic [VL_MAX-1:0] pred,
    output logic [CF_AW-1:0]  cf_rd_addr,
    input  logic [CF_W-1:0]   cf_rd_data,
    output logic              cf_wr_en,
    output logic [CF_AW-1:0]  cf_wr_addr,
    output logic [CF_W-1:0]   cf_wr_data,
    output logic              busy,
    output logic              done,
    output logic              taken,
    output logic              vl_update_valid,
    output logic [IDX_W-1:0]  new_vl,
    output logic [IDX_W-1:0]  ctr_dec_count
);
    localparam int PIDX_W = $clog2(VL_MAX);

    state_t s_q, s_d;

    logic cfg_all, cfg_sz, cfg_vlset, cfg_ins, cfg_incl;
    logic pred_bit, evaluate, el_ok, is_last, stop_now, vlset_fail;
    logic new_cond;

    always_comb begin
        cfg_all   = s_q.cfg.mode[1];
        cfg_sz    = s_q.cfg.mode[0];
        cfg_vlset = s_q.cfg.mode[3];
        cfg_ins   = s_q.cfg.mode[2] & ~s_q.cfg.mode[3];
        cfg_incl  = s_q.cfg.mode[2] &  s_q.cfg.mode[3];
        pred_bit  = s_q.cfg.pred[s_q.idx[PIDX_W-1:0]];
    end

    vbe_addr_gen #(.IDX_W(IDX_W), .CF_AW(CF_AW)) u_addr (
        .bi_hi  (s_q.cfg.bi[4:2]),
        .bi_vec (s_q.cfg.bi_vec),
        .idx    (s_q.idx),
        .addr   (cf_rd_addr)
    );

    vbe_elem_test #(.CF_W(CF_W)) u_test (
        .field    (cf_rd_data),
        .bit_sel  (s_q.cfg.bi[1:0]),
        .pred_bit (pred_bit),
        .sz       (cfg_sz),
        .ins_val  (cfg_ins),
        .bo       (s_q.cfg.bo),
        .evaluate (evaluate),
        .el_ok    (el_ok)
    );

    always_comb begin
        s_d        = s_q;
        is_last    = (s_q.idx == s_q.cfg.vl - IDX_W'(1));
        vlset_fail = evaluate & cfg_vlset & ~el_ok;
        stop_now   = evaluate & (vlset_fail | (cfg_all ? ~el_ok : el_ok));
        new_cond   = cfg_all ? (s_q.cond & el_ok) : (s_q.cond | el_ok);

        cf_wr_en   = (s_q.phase == PH_RUN) & s_q.cfg.rc_en & pred_bit;
        cf_wr_addr = CF_AW'(s_q.idx);
        cf_wr_data = cf_rd_data;

        unique case (s_q.phase)
            PH_IDLE: begin
                if (start) begin
                    s_d.cfg.bo     = bo;
                    s_d.cfg.bi     = bi;
                    s_d.cfg.bi_vec = bi_vec;
                    s_d.cfg.mode   = mode;
                    s_d.cfg.rc_en  = rc_en;
                    s_d.cfg.pred   = pred;
                    s_d.cfg.vl     = vl;
                    s_d.idx        = '0;
                    s_d.cond       = mode[1];
                    s_d.cnt        = '0;
                    s_d.vlu        = 1'b0;
                    s_d.nvl        = '0;
                    s_d.phase      = (vl == '0) ? PH_FIN : PH_RUN;
                end
            end
            PH_RUN: begin
                if (evaluate) begin
                    s_d.cond = new_cond;
                end
                if (pred_bit) begin
                    s_d.cnt = s_q.cnt + IDX_W'(1);
                end
                if (vlset_fail) begin
                    s_d.vlu = 1'b1;
                    s_d.nvl = cfg_incl ? (s_q.idx + IDX_W'(1)) : s_q.idx;
                end
                s_d.idx = s_q.idx + IDX_W'(1);
                if (stop_now || is_last) begin
                    s_d.phase = PH_FIN;
                end
            end
            PH_FIN: begin
                s_d.phase = PH_IDLE;
            end
            default: s_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.phase <= PH_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        busy            = (s_q.phase == PH_RUN);
        done            = (s_q.phase == PH_FIN);
        taken           = s_q.cond;
        vl_update_valid = s_q.vlu;
        new_vl          = s_q.nvl;
        ctr_dec_count   = s_q.cnt;
    end
endmodule

// File: rtl/vbranch_eval_chk.sv
module vbranch_eval_chk
    import vbe_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic             done,
    input logic             taken,
    input logic             cf_wr_en,
    input logic [CF_AW-1:0] cf_wr_addr,
    input logic             vl_update_valid,
    input logic [IDX_W-1:0] new_vl,
    input logic [IDX_W-1:0] ctr_dec_count
);
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R10
    AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done)); // R10
    AST_WR_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        cf_wr_en |-> busy); // R7
    AST_WR_ADDR_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        cf_wr_en |-> (cf_wr_addr < CF_AW'(VL_MAX))); // R7
    AST_CNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (ctr_dec_count <= IDX_W'(VL_MAX))); // R8
    AST_NVL_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (done && vl_update_valid) |-> (new_vl <= IDX_W'(VL_MAX))); // R6
    AST_TRUNC_NOT_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (done && vl_update_valid) |-> !taken); // R6
endmodule

bind vbranch_eval vbranch_eval_chk u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .busy            (busy),
    .done            (done),
    .taken           (taken),
    .cf_wr_en        (cf_wr_en),
    .cf_wr_addr      (cf_wr_addr),
    .vl_update_valid (vl_update_valid),
    .new_vl          (new_vl),
    .ctr_dec_count   (ctr_dec_count)
);

// File: tb/tb_vbranch_eval.sv
module tb_vbranch_eval;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 190000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [6:0]  vl = '0;
    logic [1:0]  bo = '0;
    logic [4:0]  bi = '0;
    logic        bi_vec = 1'b0;
    logic [4:0]  mode = '0;
    logic        rc_en = 1'b0;
    logic [63:0] pred = '0;
    logic [6:0]  cf_rd_addr;
    logic [3:0]  cf_rd_data;
    logic        cf_wr_en;
    logic [6:0]  cf_wr_addr;
    logic [3:0]  cf_wr_data;
    logic        busy, done, taken, vl_update_valid;
    logic [6:0]  new_vl, ctr_dec_count;

    logic [3:0] rf  [128];
    logic [3:0] mrf [128];
    int errors = 0;
    int checks = 0;
    int cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign cf_rd_data = rf[cf_rd_addr];
    always @(posedge clk) begin
        if (cf_wr_en) rf[cf_wr_addr] <= cf_wr_data;
    end

    vbranch_eval dut (
        .clk(clk), .rst_n(rst_n), .start(start), .vl(vl), .bo(bo), .bi(bi),
        .bi_vec(bi_vec), .mode(mode), .rc_en(rc_en), .pred(pred),
        .cf_rd_addr(cf_rd_addr), .cf_rd_data(cf_rd_data),
        .cf_wr_en(cf_wr_en), .cf_wr_addr(cf_wr_addr), .cf_wr_data(cf_wr_data),
        .busy(busy), .done(done), .taken(taken),
        .vl_update_valid(vl_update_valid), .new_vl(new_vl),
        .ctr_dec_count(ctr_dec_count)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > WATCHDOG) begin
            errors = errors + 1;
            $display("FAIL watchdog expired: got %0d cycles, expected below %0d", cycles, WATCHDOG);
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic run_one(input logic [6:0] v, input logic [1:0] b,
                           input logic [4:0] sel, input logic vec,
                           input logic [4:0] m, input logic rc,
                           input logic [63:0] p);
        logic e_cond, e_vlu, all_m, sz_m, ins_m, incl_m, vset_m, tb, ok;
        int e_cnt, e_nvl, e_cyc, addr, got_cyc, guard, mism;
        all_m  = m[1];
        sz_m   = m[0];
        vset_m = m[3];
        ins_m  = m[2] & ~m[3];
        incl_m = m[2] & m[3];
        for (int i = 0; i < 128; i++) mrf[i] = rf[i];
        e_cond = all_m; e_vlu = 1'b0; e_cnt = 0; e_nvl = 0; e_cyc = int'(v);
        for (int s = 0; s < int'(v); s++) begin
            if (!p[s] && !sz_m) continue;
            addr = vec ? ((int'(sel[4:2]) * 16 + s) % 128) : int'(sel[4:2]);
            if (p[s]) begin
                tb = mrf[addr][sel[1:0]];
                e_cnt++;
                if (rc) mrf[s] = mrf[addr];
            end else begin
                tb = ins_m;
            end
            ok = b[0] | ~(tb ^ b[1]);
            e_cond = all_m ? (e_cond & ok) : (e_cond | ok);
            if (vset_m && !ok) begin
                e_vlu = 1'b1;
                e_nvl = incl_m ? s + 1 : s;
                e_cyc = s + 1;
                break;
            end
            if (all_m ? !ok : ok) begin
                e_cyc = s + 1;
                break;
            end
        end
        vl = v; bo = b; bi = sel; bi_vec = vec; mode = m; rc_en = rc; pred = p;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        got_cyc = 0; guard = 0;
        while (!done && guard < 200) begin
            if (busy) got_cyc++;
            if (got_cyc == 1) begin
                start = 1'b1; vl = 7'd0; mode = ~m;
            end else begin
                start = 1'b0;
            end
            guard++;
            @(negedge clk);
        end
        start = 1'b0;
        check("R10 done reached", int'(done), 1);
        check("R3 taken", int'(taken), int'(e_cond));
        check("R6 vl_update_valid", int'(vl_update_valid), int'(e_vlu));
        if (e_vlu) check("R6 new_vl", int'(new_vl), e_nvl);
        check("R8 ctr_dec_count", int'(ctr_dec_count), e_cnt);
        check("R5 busy cycles", got_cyc, e_cyc);
        if (v == 0) check("R9 zero length count", int'(ctr_dec_count), 0);
        @(negedge clk);
        check("R10 done one cycle", int'(done), 0);
        check("R10 results held", int'(taken), int'(e_cond));
        mism = 0;
        for (int i = 0; i < 128; i++) if (rf[i] !== mrf[i]) mism++;
        check("R7 R1 R4 field contents", mism, 0);
    endtask

    initial begin
        logic [63:0] p;
        logic [6:0]  v;
        for (int i = 0; i < 128; i++) rf[i] = 4'($urandom);
        repeat (3) @(negedge clk);
        check("R10 reset busy", int'(busy), 0);
        check("R10 reset done", int'(done), 0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int m = 0; m < 32; m++) begin
            for (int b = 0; b < 4; b++) begin
                for (int k = 0; k < 4; k++) begin
                    case (k)
                        0: v = 7'd0;
                        1: v = 7'd1;
                        2: v = 7'd7;
                        default: v = 7'd64;
                    endcase
                    case ((m + b + k) % 4)
                        0: p = '1;
                        1: p = '0;
                        default: p = {$urandom, $urandom};
                    endcase
                    for (int i = 0; i < 128; i++) rf[i] = 4'($urandom);
                    run_one(v, 2'(b), 5'($urandom), 1'((m ^ k) & 1), 5'(m),
                            1'(((m >> 1) ^ b) & 1), p);
                end
            end
        end
        // R2 directed: all fields zero, bo[1]=1 fails every element in ALL mode
        for (int i = 0; i < 128; i++) rf[i] = 4'h0;
        run_one(7'd10, 2'b10, 5'b00101, 1'b1, 5'b00010, 1'b0, '1);
        // R6 directed: length-set, inclusive, fail at element 3
        for (int i = 0; i < 128; i++) rf[i] = 4'hF;
        rf[3] = 4'h0;
        run_one(7'd20, 2'b10, 5'b00000, 1'b1, 5'b01110, 1'b1, '1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule